// File: doc/BRIEF.md
# USB Host Response Checker

This block sits in the transaction path of a USB host controller. The host sends a token, and for an OUT transfer also a data packet. The block then waits for the device to answer. It measures the silence in full-speed bit times and takes in the decoded receive events: a packet start with its PID, each data byte, end of packet, and the three decoder error flags. From these it forms one 8-bit status word and a residual byte count.

A transaction begins with a one-cycle `start` pulse. That pulse carries the transfer direction and the programmed maximum length. For OUT transfers the response window opens only when the transmitter reports the end of the sent data. For IN transfers it opens at once. When the transaction ends, the block latches the status and the residue, and one clock later it raises `done` for one cycle. Line coding and CRC generation are handled elsewhere. This block only consumes their results.

Top module: `usb_resp_chk`

## Requirements
- R1: After reset, `done` is 0, `status` is 8'h00 and `xfer_count` is 8'h00.
- R2: If no packet start arrives within `TIMEOUT_BITS` (default 18) bit ticks of the window opening, the transaction ends with `status` = 8'h04 (bit 2, timeout, alone) and `xfer_count` = the programmed length.
- R3: For IN (`dir_out`=0) the window opens at `start`. For OUT (`dir_out`=1) it opens only at `tx_done`, and bit ticks before `tx_done` do not count toward the timeout.
- R4: A packet start (`rx_pid_valid`) closes the window. A response that begins after `TIMEOUT_BITS`-1 ticks does not time out.
- R5: A received PID of 4'hA sets only bit 6 (NAK). A received PID of 4'hE sets only bit 7 (STALL). At most one of bits 7, 6 and 0 is ever set.
- R6: In an OUT transfer, PID 4'h2 received without error sets bit 0 (ACK), giving status 8'h01.
- R7: In an IN transfer, a data packet with PID 4'h3 (DATA0) or 4'hB (DATA1), no error and no overflow, sets bit 0 (ACK). Bit 3 gets PID bit 3, so the status is 8'h01 for DATA0 and 8'h09 for DATA1.
- R8: A CRC5, CRC16 or PID-check error flagged between packet start and end of packet sets bit 1 (error), and ACK then stays 0.
- R9: In an IN transfer, receiving more data bytes than the programmed length sets bit 5 (overflow), and ACK then stays 0.
- R10: `xfer_count` equals the programmed length minus the received data bytes, clamped at 0. A programmed length of 0 is legal.
- R11: A PID that does not fit the direction sets bit 1 (error). Valid PIDs are a data PID for IN and 4'h2 for OUT, plus NAK and STALL for either direction.
- R12: `start` clears `status` and `xfer_count` on the next clock. `done` is a single-cycle pulse one clock after the result is latched. Bit 4 is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One pulse per full-speed bit time |
| start | input | 1 | Begins a transaction |
| dir_out | input | 1 | 1 = OUT transfer, 0 = IN transfer (sampled with start) |
| max_len | input | 8 | Programmed maximum length (sampled with start) |
| tx_done | input | 1 | End of the host's sent data (OUT) |
| rx_pid_valid | input | 1 | Incoming packet started, PID valid |
| rx_pid | input | 4 | Received PID code |
| rx_byte | input | 1 | One received data byte |
| rx_eop | input | 1 | End of received packet |
| crc5_err | input | 1 | CRC5 error flag |
| crc16_err | input | 1 | CRC16 error flag |
| pid_err | input | 1 | PID check error flag |
| done | output | 1 | Result-ready pulse |
| status | output | 8 | Packed status word |
| xfer_count | output | 8 | Residual byte count |

## Verification
On every cycle, the assertions check that the handshake bits are mutually exclusive and that ACK never coexists with error or overflow. They also check that a timeout word stands alone, that the residue never exceeds the latched length, that `done` lasts one cycle, that `start` clears the result and that the bit timer stays in range. Only the bench scenarios can show the timing of the window: that exactly the eighteenth tick expires, and that ticks before `tx_done` are ignored. They also show that each PID, error and byte count maps to the correct word and residue, including zero-length and overflow packets.

// File: rtl/usb_resp_pkg.sv
package usb_resp_pkg;

    localparam logic [3:0] PID_ACK   = 4'h2;
    localparam logic [3:0] PID_NAK   = 4'hA;
    localparam logic [3:0] PID_STALL = 4'hE;
    localparam logic [3:0] PID_DATA0 = 4'h3;
    localparam logic [3:0] PID_DATA1 = 4'hB;

    // bit order is decoded by software: must stay fixed
    typedef struct packed {
        logic stall;
        logic nak;
        logic ovf;
        logic setup;
        logic seq;
        logic tmo;
        logic err;
        logic ack;
    } resp_status_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_TXWAIT,
        S_RESP,
        S_RX,
        S_FIN
    } resp_state_t;

    function automatic logic is_data_pid(input logic [3:0] pid);
        return (pid == PID_DATA0) || (pid == PID_DATA1);
    endfunction

    function automatic resp_status_t pack_status(
        input logic       out_dir,
        input logic [3:0] pid,
        input logic       dec_err,
        input logic       ovf
    );
        resp_status_t s;
        logic hs, expected, bad;
        s        = '0;
        hs       = (pid == PID_NAK) || (pid == PID_STALL);
        expected = out_dir ? (pid == PID_ACK) : is_data_pid(pid);
        bad      = dec_err || !(hs || expected);
        s.stall  = (pid == PID_STALL);
        s.nak    = (pid == PID_NAK);
        s.err    = bad;
        if (!out_dir && is_data_pid(pid)) begin
            s.seq = pid[3];
            s.ovf = ovf;
            s.ack = !bad && !ovf;
        end else if (out_dir && pid == PID_ACK) begin
            s.ack = !bad;
        end
        return s;
    endfunction

    function automatic resp_status_t timeout_status();
        resp_status_t s;
        s     = '0;
        s.tmo = 1'b1;
        return s;
    endfunction

endpackage

// File: rtl/usb_resp_timer.sv
module usb_resp_timer #(
    parameter int LIMIT = 18
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    input  logic tick,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    assign expired = run && tick && (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (run && tick && !expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    p_timer_bound_r2: assert property (@(posedge clk) disable iff (rst)
        cnt < CW'(LIMIT));

endmodule

// File: rtl/usb_resp_bytecnt.sv
module usb_resp_bytecnt #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         inc,
    output logic [W-1:0] bytes
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            bytes <= '0;
        end else if (inc && !(&bytes)) begin
            bytes <= bytes + 1'b1;
        end
    end

    p_bytes_monotonic_r10: assert property (@(posedge clk) disable iff (rst)
        !clear |=> bytes >= $past(bytes));

endmodule

// File: rtl/usb_resp_chk.sv
module usb_resp_chk
    import usb_resp_pkg::*;
#(
    parameter int LEN_W        = 8,
    parameter int TIMEOUT_BITS = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_tick,
    input  logic             start,
    input  logic             dir_out,
    input  logic [LEN_W-1:0] max_len,
    input  logic             tx_done,
    input  logic             rx_pid_valid,
    input  logic [3:0]       rx_pid,
    input  logic             rx_byte,
    input  logic             rx_eop,
    input  logic             crc5_err,
    input  logic             crc16_err,
    input  logic             pid_err,
    output logic             done,
    output logic [7:0]       status,
    output logic [LEN_W-1:0] xfer_count
);
    localparam int BW = LEN_W + 1;

    resp_state_t      state;
    logic             dir_q;
    logic [LEN_W-1:0] len_q;
    logic [3:0]       pid_q;
    logic             err_q;
    resp_status_t     status_q;
    logic [LEN_W-1:0] count_q;
    logic             done_q;

    logic             expired;
    logic [BW-1:0]    bytes;
    logic             err_now;
    logic             ovf;
    logic [LEN_W-1:0] residue;
    logic             tmr_clear;

    assign err_now   = crc5_err || crc16_err || pid_err;
    assign tmr_clear = start || (state == S_TXWAIT && tx_done) || rx_pid_valid;
    assign ovf       = bytes > {1'b0, len_q};
    assign residue   = (bytes >= {1'b0, len_q}) ? '0 : (len_q - bytes[LEN_W-1:0]);

    usb_resp_timer #(.LIMIT(TIMEOUT_BITS)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clear   (tmr_clear),
        .run     (state == S_RESP),
        .tick    (bit_tick),
        .expired (expired)
    );

    usb_resp_bytecnt #(.W(BW)) u_bytes (
        .clk   (clk),
        .rst   (rst),
        .clear (start),
        .inc   (state == S_RX && rx_byte),
        .bytes (bytes)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            dir_q    <= 1'b0;
            len_q    <= '0;
            pid_q    <= '0;
            err_q    <= 1'b0;
            status_q <= '0;
            count_q  <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= (state == S_FIN);
            if (start) begin
                status_q <= '0;
                count_q  <= '0;
                err_q    <= 1'b0;
                dir_q    <= dir_out;
                len_q    <= max_len;
                state    <= dir_out ? S_TXWAIT : S_RESP;
            end else begin
                unique case (state)
                    S_TXWAIT: if (tx_done) state <= S_RESP;
                    S_RESP: begin
                        if (rx_pid_valid) begin
                            pid_q <= rx_pid;
                            err_q <= err_now;
                            state <= S_RX;
                        end else if (expired) begin
                            status_q <= timeout_status();
                            count_q  <= len_q;
                            state    <= S_FIN;
                        end
                    end
                    S_RX: begin
                        err_q <= err_q || err_now;
                        if (rx_eop) begin
                            status_q <= pack_status(dir_q, pid_q, err_q || err_now, ovf);
                            count_q  <= residue;
                            state    <= S_FIN;
                        end
                    end
                    S_FIN:   state <= S_IDLE;
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    assign done       = done_q;
    assign status     = status_q;
    assign xfer_count = count_q;

    p_handshake_onehot_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({status_q.stall, status_q.nak, status_q.ack}));

    p_ack_clean_r8: assert property (@(posedge clk) disable iff (rst)
        status_q.ack |-> !(status_q.err || status_q.ovf));

    p_timeout_alone_r2: assert property (@(posedge clk) disable iff (rst)
        status_q.tmo |-> (status_q == timeout_status()));

    p_count_bound_r10: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (count_q <= len_q));

    p_clear_on_start_r12: assert property (@(posedge clk) disable iff (rst)
        start |=> (status_q == '0 && count_q == '0));

    p_done_single_r12: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    p_txwait_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (state == S_TXWAIT && !tx_done && !start) |=> state == S_TXWAIT);

endmodule

// File: tb/usb_resp_chk_tb.sv
module usb_resp_chk_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_tick = 0, start = 0, dir_out = 0, tx_done = 0;
    logic [7:0] max_len = 0;
    logic       rx_pid_valid = 0, rx_byte = 0, rx_eop = 0;
    logic [3:0] rx_pid = 0;
    logic       crc5_err = 0, crc16_err = 0, pid_err = 0;
    logic       done;
    logic [7:0] status, xfer_count;

    int checks = 0, errors = 0, done_seen = 0;
    logic [7:0] cap_status, cap_count;
    bit finished = 0;

    always #4 clk = ~clk;

    usb_resp_chk u_dut (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .start(start),
        .dir_out(dir_out), .max_len(max_len), .tx_done(tx_done),
        .rx_pid_valid(rx_pid_valid), .rx_pid(rx_pid), .rx_byte(rx_byte),
        .rx_eop(rx_eop), .crc5_err(crc5_err), .crc16_err(crc16_err),
        .pid_err(pid_err), .done(done), .status(status), .xfer_count(xfer_count)
    );

    always @(negedge clk) begin
        if (done) begin
            done_seen  <= done_seen + 1;
            cap_status <= status;
            cap_count  <= xfer_count;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    function automatic logic [7:0] exp_status(input bit outd, input logic [3:0] pid,
                                              input int nb, input int len, input bit err);
        logic [7:0] s = 8'h00;
        bit data = (pid == 4'h3) || (pid == 4'hB);
        bit fits = (pid == 4'hA) || (pid == 4'hE) || (outd ? pid == 4'h2 : data);
        bit e = err || !fits;
        if (pid == 4'hA) s[6] = 1;
        if (pid == 4'hE) s[7] = 1;
        s[1] = e;
        if (!outd && data) begin
            s[3] = pid[3];
            s[5] = nb > len;
            s[0] = !e && !(nb > len);
        end
        if (outd && pid == 4'h2) s[0] = !e;
        return s;
    endfunction

    function automatic int exp_count(input int nb, input int len);
        return (nb >= len) ? 0 : len - nb;
    endfunction

    task automatic do_start(input bit outd, input logic [7:0] len);
        start = 1; dir_out = outd; max_len = len;
        step();
        start = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1; step();
            bit_tick = 0; step();
        end
    endtask

    task automatic wait_done(input int base, output bit got);
        got = 0;
        for (int i = 0; i < 200 && !got; i++) begin
            @(negedge clk);
            #1;
            if (done_seen > base) got = 1;
        end
    endtask

    // ek: 0 none, 1 pid_err at start, 2 crc16 at eop, 3 crc5 at eop
    task automatic transact(input bit outd, input logic [7:0] len, input logic [3:0] pid,
                            input int nb, input int ek, input int lat, input string req);
        int base = done_seen;
        bit got;
        logic [7:0] es;
        int ec;
        do_start(outd, len);
        if (outd) begin
            step(); step();
            tx_done = 1; step(); tx_done = 0;
        end
        ticks(lat);
        rx_pid_valid = 1; rx_pid = pid; pid_err = (ek == 1);
        step();
        rx_pid_valid = 0; pid_err = 0;
        for (int i = 0; i < nb; i++) begin
            rx_byte = 1; step(); rx_byte = 0; step();
        end
        rx_eop = 1; crc16_err = (ek == 2); crc5_err = (ek == 3);
        step();
        rx_eop = 0; crc16_err = 0; crc5_err = 0;
        wait_done(base, got);
        es = exp_status(outd, pid, nb, len, ek != 0);
        ec = exp_count(nb, len);
        chk(got, {req, " done seen"}, got, 1);
        chk(cap_status == es, {req, " status"}, cap_status, es);
        chk(cap_count == ec[7:0], {req, " count"}, cap_count, ec);
        chk(cap_status[4] == 1'b0, "R12 setup bit zero", cap_status[4], 0);
    endtask

    initial begin
        repeat (120000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int base;
        bit got;
        void'($urandom(32'd1234));
        repeat (3) step();
        rst = 0;
        @(negedge clk);
        chk(done == 0 && status == 0 && xfer_count == 0, "R1 reset state",
            {done, status, xfer_count}, 0);

        // R2 timeout on IN after 18 ticks
        base = done_seen;
        do_start(0, 8'd12);
        ticks(18);
        wait_done(base, got);
        chk(got, "R2 timeout done", got, 1);
        chk(cap_status == 8'h04, "R2 timeout status", cap_status, 8'h04);
        chk(cap_count == 8'd12, "R2 timeout count", cap_count, 12);

        // R12 start clears result
        do_start(0, 8'd5);
        @(negedge clk);
        chk(status == 0 && xfer_count == 0, "R12 clear on start", status, 0);
        ticks(18);
        wait_done(base + 1, got);
        chk(got, "R12 second timeout done", got, 1);
        chk(done_seen == base + 2, "R12 single done pulse", done_seen, base + 2);

        // R3 OUT ignores ticks before tx_done
        base = done_seen;
        do_start(1, 8'd7);
        ticks(30);
        chk(done_seen == base, "R3 no timeout before tx_done", done_seen, base);
        tx_done = 1; step(); tx_done = 0;
        ticks(17);
        chk(done_seen == base, "R3 no timeout at 17 ticks", done_seen, base);
        ticks(1);
        wait_done(base, got);
        chk(got && cap_status == 8'h04, "R3 timeout after tx_done", cap_status, 8'h04);

        // R4 response after 17 ticks
        transact(0, 8'd4, 4'h3, 4, 0, 17, "R4 late response");
        // R5 / R6 / R7 directed
        transact(0, 8'd8, 4'hA, 0, 0, 2, "R5 NAK");
        transact(1, 8'd8, 4'hE, 0, 0, 3, "R5 STALL");
        transact(1, 8'd3, 4'h2, 0, 0, 1, "R6 ACK");
        transact(0, 8'd6, 4'h3, 6, 0, 1, "R7 DATA0");
        transact(0, 8'd6, 4'hB, 2, 0, 1, "R7 DATA1 short");
        // R8 errors
        transact(0, 8'd6, 4'hB, 3, 2, 1, "R8 crc16");
        transact(1, 8'd6, 4'h2, 0, 3, 1, "R8 crc5");
        transact(0, 8'd6, 4'h3, 1, 1, 1, "R8 pid err");
        // R9 / R10 overflow and zero length
        transact(0, 8'd4, 4'h3, 6, 0, 1, "R9 overflow");
        transact(0, 8'd0, 4'hB, 0, 0, 1, "R10 zero length");
        transact(0, 8'd0, 4'hB, 1, 0, 1, "R9 zero length overflow");
        // R11 unexpected PID
        transact(0, 8'd5, 4'h2, 0, 0, 1, "R11 ACK on IN");
        transact(1, 8'd5, 4'h3, 0, 0, 1, "R11 DATA0 on OUT");

        // random mix
        for (int n = 0; n < 40; n++) begin
            bit outd = $urandom_range(0, 1);
            logic [7:0] len = 8'($urandom_range(0, 20));
            logic [3:0] pid;
            int nb = 0;
            int sel = $urandom_range(0, 3);
            int ek = ($urandom_range(0, 4) == 0) ? $urandom_range(1, 3) : 0;
            if (outd) pid = (sel == 0) ? 4'hA : (sel == 1) ? 4'hE : 4'h2;
            else begin
                pid = (sel == 0) ? 4'hA : (sel == 1) ? 4'hE : (sel == 2) ? 4'h3 : 4'hB;
                if (sel >= 2) nb = $urandom_range(0, int'(len) + 3);
            end
            transact(outd, len, pid, nb, ek, $urandom_range(0, 17), "R10 random");
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule